// File: doc/BRIEF.md
# USB OUT Endpoint Handshake Controller

This block sits beside the packet engine of a USB device controller and decides how a bulk or interrupt OUT endpoint answers each transaction. The packet engine hands it decoded events: an OUT token for this endpoint, the start of the data packet with its DATA0/DATA1 identifier, each received byte, a receive-error pulse (CRC, bit-stuff or PID fault) and end of packet. The block forwards accepted bytes to the receive FIFO storage. It then commits or discards them and issues a one-cycle handshake strobe carrying a 2-bit code.

The controller keeps a small status set for the CPU: halted, FIFO-enable, a sticky stall flag, the expected data toggle and the committed byte count. It raises a one-cycle interrupt only when a packet is really taken into the FIFO. The CPU drives pulses for halt, clear-halt, FIFO-enable and FIFO flush, and a level for endpoint select.

Control is a four-state machine. IDLE goes to TOKEN on an OUT token. TOKEN goes to DATA on data-packet start. DATA goes to REPLY on end of packet. REPLY always returns to IDLE after one cycle. A verdict is registered on the DATA-to-REPLY transition, and all REPLY-cycle outputs come from that verdict.

Top module: `oep_handshake_ctrl`

## Requirements
- R1: After reset no strobe, interrupt, commit or drop is active, and halted, FIFO-enable, stall flag, expected toggle (DATA0 = 0) and byte count are all zero.
- R2: A packet with no fault goes to the FIFO when the toggle matches, FIFO-enable is set, the endpoint is not halted and the stall flag is clear. In the cycle after end of packet the block strobes ACK (code 1), pulses commit and the interrupt, latches the byte count, clears FIFO-enable and flips the expected toggle.
- R3: A receive error during the token or data phase gives code NONE (0). The block also raises no interrupt, pulses drop, and leaves FIFO-enable, toggle and count unchanged.
- R4: A data PID that differs from the expected toggle, with no fault and the endpoint not halted, gives ACK whatever FIFO-enable is. The data is dropped, no interrupt is raised and the toggle is unchanged.
- R5: More bytes than the FIFO room sampled at data start is an overrun. No byte beyond the room is written, the code is NONE, no interrupt is raised and FIFO-enable is unchanged.
- R6: A CPU flush during the data phase gives code NONE and clears the byte count.
- R7: A halted endpoint answers a fault-free packet with STALL (code 3), drops the data and sets the stall flag. Setting halt also clears FIFO-enable.
- R8: Clear-halt resets the expected toggle to DATA0. Packets are only committed again after FIFO-enable is also set.
- R9: The stall flag stays set until endpoint select falls. While it is set, a packet that would otherwise be committed is answered NAK and no status changes.
- R10: With FIFO-enable clear, a fault-free, matching-toggle packet to a non-halted endpoint gets NAK (code 2) and is dropped.
- R11: The handshake strobe lasts exactly one cycle, and the interrupt only occurs together with an ACK strobe and a commit.
- R12: Each received byte is written to the FIFO in the cycle it arrives, only during the data phase and only while below the sampled room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_out_tok | input | 1 | OUT token for this endpoint seen |
| pkt_data_start | input | 1 | Data packet begins |
| pkt_data_pid | input | 1 | Data PID, 0 = DATA0, 1 = DATA1 (valid with start) |
| pkt_byte_vld | input | 1 | Received byte valid |
| pkt_byte | input | 8 | Received byte |
| pkt_err | input | 1 | Receive error pulse |
| pkt_eop | input | 1 | End of data packet |
| fifo_room | input | CW | Free FIFO bytes, sampled at data start |
| ep_halt_set | input | 1 | Halt request from CPU or host feature request |
| cpu_clr_halt | input | 1 | CPU clear-halt pulse |
| cpu_fifo_en_set | input | 1 | CPU FIFO-enable pulse |
| cpu_flush | input | 1 | CPU FIFO flush pulse |
| cpu_ep_sel | input | 1 | CPU endpoint select level |
| fifo_wr_en | output | 1 | FIFO byte write |
| fifo_wr_data | output | 8 | FIFO byte data |
| fifo_commit | output | 1 | Keep the written packet |
| fifo_drop | output | 1 | Discard the written packet |
| hs_vld | output | 1 | Handshake decision strobe |
| hs_code | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |
| irq | output | 1 | Packet-received interrupt pulse |
| stat_halted | output | 1 | Endpoint halted |
| stat_fifo_en | output | 1 | FIFO-enable flag |
| stat_stall | output | 1 | Sticky stall flag |
| stat_toggle | output | 1 | Expected data toggle |
| rx_count | output | CW | Committed byte count |

## Verification
The embedded assertions check, on every cycle, properties that need no knowledge of the stimulus. These are the single-cycle strobe, an interrupt only with an ACK commit, no commit after a halted cycle, the write count never passing the sampled room, and the status effects of clear-halt, stall and select fall. Only the bench's scenarios can show the decision priority: an error or overrun beating a halt, a halt beating a toggle mismatch, and a mismatch beating NAK. The same holds for the exact latched count and for the recovery order after a halt. The bench follows these with its own model over directed and seeded random packets.

// File: rtl/oep_pkg.sv
package oep_pkg;
    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_code_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TOKEN,
        ST_DATA,
        ST_REPLY
    } oep_state_t;

    typedef struct packed {
        hs_code_t code;
        logic     commit;
    } verdict_t;
endpackage

// File: rtl/oep_rx_meter.sv
module oep_rx_meter #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          byte_in,
    input  logic [CW-1:0] room,
    output logic          wr_ok,
    output logic          overrun,
    output logic [CW-1:0] bcnt
);
    logic [CW-1:0] room_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            room_q  <= '0;
            bcnt    <= '0;
            overrun <= 1'b0;
        end else if (start) begin
            room_q  <= room;
            bcnt    <= '0;
            overrun <= 1'b0;
        end else if (byte_in) begin
            if (bcnt < room_q) bcnt <= bcnt + 1'b1;
            else               overrun <= 1'b1;
        end
    end

    assign wr_ok = byte_in && (bcnt < room_q);

    // R12
    room_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt <= room_q);
endmodule

// File: rtl/oep_ep_status.sv
module oep_ep_status #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt_set,
    input  logic          clr_halt,
    input  logic          fen_set,
    input  logic          flush,
    input  logic          ep_sel,
    input  logic          commit,
    input  logic [CW-1:0] commit_cnt,
    input  logic          stall_upd,
    output logic          halted,
    output logic          fifo_en,
    output logic          stall_flag,
    output logic          exp_tog,
    output logic [CW-1:0] count
);
    logic sel_q;
    logic sel_fall;

    assign sel_fall = sel_q && !ep_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted     <= 1'b0;
            fifo_en    <= 1'b0;
            stall_flag <= 1'b0;
            exp_tog    <= 1'b0;
            count      <= '0;
            sel_q      <= 1'b0;
        end else begin
            sel_q <= ep_sel;
            if (halt_set)      halted <= 1'b1;
            else if (clr_halt) halted <= 1'b0;

            if (halt_set)     fifo_en <= 1'b0;
            else if (commit)  fifo_en <= 1'b0;
            else if (fen_set) fifo_en <= 1'b1;

            if (clr_halt)    exp_tog <= 1'b0;
            else if (commit) exp_tog <= ~exp_tog;

            if (flush)       count <= '0;
            else if (commit) count <= commit_cnt;

            if (sel_fall)       stall_flag <= 1'b0;
            else if (stall_upd) stall_flag <= 1'b1;
        end
    end

    // R8
    clr_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_halt && !halt_set && !commit) |=> (!halted && !exp_tog));
    // R7
    stall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_upd && ep_sel) |=> stall_flag);
    // R9
    stall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ep_sel) && !stall_upd) |=> !stall_flag);
endmodule

// File: rtl/oep_handshake_ctrl.sv
module oep_handshake_ctrl
    import oep_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pkt_out_tok,
    input  logic          pkt_data_start,
    input  logic          pkt_data_pid,
    input  logic          pkt_byte_vld,
    input  logic [7:0]    pkt_byte,
    input  logic          pkt_err,
    input  logic          pkt_eop,
    input  logic [CW-1:0] fifo_room,
    input  logic          ep_halt_set,
    input  logic          cpu_clr_halt,
    input  logic          cpu_fifo_en_set,
    input  logic          cpu_flush,
    input  logic          cpu_ep_sel,
    output logic          fifo_wr_en,
    output logic [7:0]    fifo_wr_data,
    output logic          fifo_commit,
    output logic          fifo_drop,
    output logic          hs_vld,
    output logic [1:0]    hs_code,
    output logic          irq,
    output logic          stat_halted,
    output logic          stat_fifo_en,
    output logic          stat_stall,
    output logic          stat_toggle,
    output logic [CW-1:0] rx_count
);
    oep_state_t    state_q, state_d;
    verdict_t      verdict_q, verdict_d;
    logic          err_q, flush_q, pid_q;
    logic          meter_start, meter_byte, wr_ok, overrun;
    logic [CW-1:0] bcnt;
    logic          halted, fifo_en, stall_flag, exp_tog;
    logic          bad;

    assign meter_start = (state_q == ST_TOKEN) && pkt_data_start;
    assign meter_byte  = (state_q == ST_DATA) && pkt_byte_vld;

    oep_rx_meter #(.CW(CW)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (meter_start),
        .byte_in (meter_byte),
        .room    (fifo_room),
        .wr_ok   (wr_ok),
        .overrun (overrun),
        .bcnt    (bcnt)
    );

    oep_ep_status #(.CW(CW)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_set   (ep_halt_set),
        .clr_halt   (cpu_clr_halt),
        .fen_set    (cpu_fifo_en_set),
        .flush      (cpu_flush),
        .ep_sel     (cpu_ep_sel),
        .commit     (fifo_commit),
        .commit_cnt (bcnt),
        .stall_upd  (hs_vld && (hs_code == HS_STALL)),
        .halted     (halted),
        .fifo_en    (fifo_en),
        .stall_flag (stall_flag),
        .exp_tog    (exp_tog),
        .count      (rx_count)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pkt_out_tok)    state_d = ST_TOKEN;
            ST_TOKEN: if (pkt_data_start) state_d = ST_DATA;
            ST_DATA:  if (pkt_eop)        state_d = ST_REPLY;
            ST_REPLY:                     state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // per-transaction fault tracking and verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q     <= 1'b0;
            flush_q   <= 1'b0;
            pid_q     <= 1'b0;
            verdict_q <= '{code: HS_NONE, commit: 1'b0};
        end else begin
            if (state_q == ST_IDLE && pkt_out_tok) begin
                err_q   <= pkt_err;
                flush_q <= 1'b0;
            end else if (state_q == ST_TOKEN || state_q == ST_DATA) begin
                err_q <= err_q | pkt_err;
            end
            if (state_q == ST_DATA) flush_q <= flush_q | cpu_flush;
            if (meter_start) pid_q <= pkt_data_pid;
            if (state_q == ST_DATA && pkt_eop) verdict_q <= verdict_d;
        end
    end

    assign bad = err_q | pkt_err | flush_q | cpu_flush | overrun;

    // decision priority: fault, halt, toggle, availability
    always_comb begin
        verdict_d = '{code: HS_ACK, commit: 1'b1};
        if (bad)                       verdict_d = '{code: HS_NONE,  commit: 1'b0};
        else if (halted)               verdict_d = '{code: HS_STALL, commit: 1'b0};
        else if (pid_q != exp_tog)     verdict_d = '{code: HS_ACK,   commit: 1'b0};
        else if (!fifo_en || stall_flag) verdict_d = '{code: HS_NAK, commit: 1'b0};
    end

    // outputs
    always_comb begin
        hs_vld       = (state_q == ST_REPLY);
        hs_code      = hs_vld ? verdict_q.code : HS_NONE;
        fifo_commit  = hs_vld && verdict_q.commit;
        fifo_drop    = hs_vld && !verdict_q.commit;
        irq          = fifo_commit;
        fifo_wr_en   = wr_ok;
        fifo_wr_data = pkt_byte;
        stat_halted  = halted;
        stat_fifo_en = fifo_en;
        stat_stall   = stall_flag;
        stat_toggle  = exp_tog;
    end

    // R11
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_vld |=> !hs_vld);
    // R11
    irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (hs_vld && hs_code == HS_ACK && fifo_commit));
    // R7
    no_commit_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_commit |-> !$past(halted));
    // R12
    write_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> (state_q == ST_DATA && pkt_byte_vld));
    // R2
    commit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_commit && fifo_drop));
endmodule

// File: tb/test_oep_handshake_ctrl.sv
`timescale 1ns/1ps
module test_oep_handshake_ctrl;
    localparam int DEPTH = 64;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_out_tok = 0, pkt_data_start = 0, pkt_data_pid = 0, pkt_byte_vld = 0;
    logic [7:0] pkt_byte = '0;
    logic pkt_err = 0, pkt_eop = 0;
    logic [CW-1:0] fifo_room = '0;
    logic ep_halt_set = 0, cpu_clr_halt = 0, cpu_fifo_en_set = 0, cpu_flush = 0;
    logic cpu_ep_sel = 1'b1;
    logic fifo_wr_en, fifo_commit, fifo_drop, hs_vld, irq;
    logic [7:0] fifo_wr_data;
    logic [1:0] hs_code;
    logic stat_halted, stat_fifo_en, stat_stall, stat_toggle;
    logic [CW-1:0] rx_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the status
    int m_halted = 0, m_fen = 0, m_stall = 0, m_tog = 0, m_count = 0;

    always #4 clk = ~clk;

    oep_handshake_ctrl #(.DEPTH(DEPTH)) i_oep_handshake_ctrl (
        .clk(clk), .rst_n(rst_n), .pkt_out_tok(pkt_out_tok),
        .pkt_data_start(pkt_data_start), .pkt_data_pid(pkt_data_pid),
        .pkt_byte_vld(pkt_byte_vld), .pkt_byte(pkt_byte), .pkt_err(pkt_err),
        .pkt_eop(pkt_eop), .fifo_room(fifo_room), .ep_halt_set(ep_halt_set),
        .cpu_clr_halt(cpu_clr_halt), .cpu_fifo_en_set(cpu_fifo_en_set),
        .cpu_flush(cpu_flush), .cpu_ep_sel(cpu_ep_sel), .fifo_wr_en(fifo_wr_en),
        .fifo_wr_data(fifo_wr_data), .fifo_commit(fifo_commit),
        .fifo_drop(fifo_drop), .hs_vld(hs_vld), .hs_code(hs_code), .irq(irq),
        .stat_halted(stat_halted), .stat_fifo_en(stat_fifo_en),
        .stat_stall(stat_stall), .stat_toggle(stat_toggle), .rx_count(rx_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_status(input string req);
        chk({req, " halted"}, int'(stat_halted), m_halted);
        chk({req, " fifo_en"}, int'(stat_fifo_en), m_fen);
        chk({req, " stall"}, int'(stat_stall), m_stall);
        chk({req, " toggle"}, int'(stat_toggle), m_tog);
        chk({req, " count"}, int'(rx_count), m_count);
    endtask

    // expected code: 0 none, 1 ack, 2 nak, 3 stall; commit returned separately
    function automatic int exp_code(input bit bad, input int pid, output bit commit);
        commit = 0;
        if (bad) return 0;
        if (m_halted != 0) return 3;
        if (pid != m_tog) return 1;
        if (m_fen == 0 || m_stall != 0) return 2;
        commit = 1;
        return 1;
    endfunction

    // err_at: -1 none, -2 token phase, else byte index; flush_at: -1 none, else byte index
    task automatic send_pkt(input string req, input int pid, input int n, input int room,
                            input int err_at, input int flush_at);
        int writes = 0;
        bit bad, commit;
        int code;
        @(negedge clk);
        pkt_out_tok = 1; pkt_err = (err_at == -2);
        @(negedge clk);
        pkt_out_tok = 0; pkt_err = 0;
        pkt_data_start = 1; pkt_data_pid = pid[0]; fifo_room = CW'(room);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pkt_data_start = 0;
            pkt_byte_vld = 1; pkt_byte = 8'($urandom);
            pkt_err = (err_at == i); cpu_flush = (flush_at == i);
            #1;
            if (fifo_wr_en) writes++;
        end
        @(negedge clk);
        pkt_data_start = 0; pkt_byte_vld = 0; pkt_err = 0; cpu_flush = 0;
        pkt_eop = 1;
        @(negedge clk);
        pkt_eop = 0;
        bad = (err_at != -1) || (flush_at >= 0 && flush_at < n) || (n > room);
        if (flush_at >= 0 && flush_at < n) m_count = 0;
        code = exp_code(bad, pid, commit);
        #1;
        chk({req, " R11 strobe"}, int'(hs_vld), 1);
        chk({req, " handshake code"}, int'(hs_code), code);
        chk({req, " R11 irq"}, int'(irq), int'(commit));
        chk({req, " commit"}, int'(fifo_commit), int'(commit));
        chk({req, " drop"}, int'(fifo_drop), int'(!commit));
        chk({req, " R12 writes"}, writes, (n < room) ? n : room);
        if (commit) begin
            m_count = n; m_fen = 0; m_tog = 1 - m_tog;
        end
        if (code == 3) m_stall = 1;
        @(negedge clk);
        #1;
        chk({req, " R11 one cycle"}, int'(hs_vld), 0);
        chk_status(req);
    endtask

    task automatic cpu_act(input int kind);
        @(negedge clk);
        case (kind)
            0: begin ep_halt_set = 1; m_halted = 1; m_fen = 0; end
            1: begin cpu_clr_halt = 1; m_halted = 0; m_tog = 0; end
            2: begin cpu_fifo_en_set = 1; m_fen = 1; end
            3: begin cpu_ep_sel = 0; m_stall = 0; end
            4: begin cpu_flush = 1; m_count = 0; end
            default: ;
        endcase
        @(negedge clk);
        ep_halt_set = 0; cpu_clr_halt = 0; cpu_fifo_en_set = 0;
        cpu_ep_sel = 1; cpu_flush = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 strobe", int'(hs_vld), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 commit", int'(fifo_commit), 0);
        chk_status("R1");

        cpu_act(2);
        send_pkt("R2 good", 0, 5, 64, -1, -1);
        send_pkt("R10 fifo disabled", 1, 3, 64, -1, -1);
        send_pkt("R4 toggle mismatch fen clear", 0, 4, 64, -1, -1);
        cpu_act(2);
        send_pkt("R4 toggle mismatch fen set", 0, 2, 64, -1, -1);
        send_pkt("R3 data error", 1, 6, 64, 2, -1);
        send_pkt("R3 token error", 1, 3, 64, -2, -1);
        send_pkt("R5 overrun", 1, 10, 4, -1, -1);
        send_pkt("R2 exact fit", 1, 4, 4, -1, -1);
        cpu_act(2);
        send_pkt("R6 flush mid packet", 0, 6, 64, -1, 3);
        cpu_act(0);
        send_pkt("R7 halted", 0, 3, 64, -1, -1);
        send_pkt("R3 error beats halt", 0, 3, 64, 0, -1);
        cpu_act(1);
        send_pkt("R8 after clear-halt only", 0, 3, 64, -1, -1);
        cpu_act(2);
        send_pkt("R9 stall held", 0, 3, 64, -1, -1);
        cpu_act(3);
        #1 chk("R9 stall cleared by deselect", int'(stat_stall), 0);
        send_pkt("R8 recovered", 0, 7, 64, -1, -1);
        send_pkt("R2 zero length", 1, 0, 64, -1, -1);

        for (int k = 0; k < 300; k++) begin
            int r = $urandom % 20;
            int n = $urandom % 17;
            int room = 16 + ($urandom % 49);
            int pid = (($urandom % 4) == 0) ? (1 - m_tog) : m_tog;
            int err_at = -1;
            int flush_at = -1;
            if (r < 5) cpu_act(r);
            else if (r < 12) cpu_act(2);
            if (($urandom % 10) == 0 && n > 0) room = $urandom % n;
            if (($urandom % 10) == 0) err_at = (n > 0) ? int'($urandom % n) : -2;
            if (($urandom % 15) == 0 && n > 0) flush_at = $urandom % n;
            send_pkt("random", pid, n, room, err_at, flush_at);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule